// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block computes the matrix product C = X·W on a square N×N grid of multiply-accumulate cells. A load phase comes first. Over N cycles it shifts one row of W per cycle down the grid, so each cell ends up holding one fixed weight. Rows of X then stream in from the left edge. Each cell multiplies the activation it receives by its stored weight, adds the partial sum coming from the cell above, and passes the activation to the cell on its right. Finished entries of C leave the bottom of each column.

The caller skews the input: element i of an X row enters array row i exactly i cycles after element 0. A single input valid travels through a matching chain of registers, so each column raises its own result-valid in the same cycle its result appears. Once the grid is full, one new row of C appears every cycle. A batch of M rows therefore finishes within about M + 2N cycles.

All arithmetic is unsigned. Each partial sum is carried at 2·DW + ceil(log2 N) bits, so no result can wrap.

Top module: `wsmm_array`

## Requirements
- R1: Synchronous active-low reset clears every weight, activation register, partial sum and valid bit. In the cycle after a reset edge, `res_valid` and `res_out` are all zero, and results computed before a new load are zero.
- R2: While `load_en` is high, at each clock edge every cell takes the weight of the cell above it. The top row takes column j from `load_row[j*DW +: DW]`. After N consecutive load cycles, the row driven in load cycle k (counting from 0) sits in array row N-1-k. While `load_en` is low, every weight holds and `load_row` has no effect.
- R3: Each cell registers the activation it receives and presents it unchanged to its right neighbour one cycle later.
- R4: At each edge, a cell's partial-sum output becomes the partial sum from above plus activation × weight. The top row sees a partial sum of zero. Sums are unsigned and AW = 2·DW + ceil(log2 N) bits wide.
- R5: Suppose `act_in[i*DW +: DW]` carries X[k][i] at the edge t+i. Then `res_out[j*AW +: AW]` equals the sum over i of X[k][i]·W[i][j] right after edge t+N-1+j, where W[i][j] is the weight in array row i, column j.
- R6: `res_valid[j]` is high right after edge t+N-1+j exactly when `in_valid` was high at edge t. Gaps in `in_valid` appear as matching gaps at every column, and activations sampled with `in_valid` low produce no valid result.
- R7: With back-to-back valid rows, every column delivers one result per cycle. A batch of M rows yields exactly M·N valid results, the last one visible after edge t+M+2N-3.
- R8: With every activation and weight at its maximum 2^DW-1, each result equals N·(2^DW-1)^2 exactly, with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every cell updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Shifts weights one row down the grid when high |
| load_row | input | N*DW | Weight row entering the top of the grid; column j at bits [j*DW +: DW] |
| in_valid | input | 1 | Marks the cycle in which element 0 of an X row enters array row 0 |
| act_in | input | N*DW | Left-edge activations, already skewed; array row i at bits [i*DW +: DW] |
| res_valid | output | N | Per-column flag that `res_out` holds a finished entry of C |
| res_out | output | N*AW | Bottom-edge results; column j at bits [j*AW +: AW] |

## Verification
The assertions check the local cell contract on every cycle: weights hold outside the load phase, weights move exactly one row per load cycle, activations shift one column per cycle, each multiply-add step is exact, and each column's valid lags its left neighbour by one cycle. They also check that reset clears the outputs. Only the bench scenarios can show that these local steps add up to the correct product on the skewed timing. Those scenarios cover where loaded rows land, the exact cycle each result appears, that no result wraps at maximum operands, that gaps in valid are preserved, and that results are zero after a reset clears the weights.

// File: rtl/wsmm_pkg.sv
// Shared helpers for the weight-stationary matrix multiplier.
// Assumes: unsigned operands; width helpers are evaluated at elaboration.
package wsmm_pkg;

    // Partial-sum width that holds a sum of n_dim products of data_w-bit operands without wrapping.
    function automatic int acc_width(input int data_w, input int n_dim);
        return 2 * data_w + $clog2(n_dim);
    endfunction

    // Length of the valid delay line: the right-most column lags the input by 2N-1 edges.
    function automatic int valid_depth(input int n_dim);
        return 2 * n_dim - 1;
    endfunction

endpackage

// File: rtl/wsmm_cell.sv
// One multiply-accumulate cell of the grid.
// Holds a weight that changes only while load_en is high (taken from the cell above).
// Every edge: registers the incoming activation for the right neighbour and
// registers (partial sum from above + activation * weight) for the cell below.
// Assumes: unsigned operands; AW is wide enough for the column sum.
module wsmm_cell #(
    parameter int DW = 8,
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [DW-1:0] w_in,
    output logic [DW-1:0] w_out,
    input  logic [DW-1:0] a_in,
    output logic [DW-1:0] a_out,
    input  logic [AW-1:0] p_in,
    output logic [AW-1:0] p_out
);

    logic [DW-1:0] w_q;
    logic [DW-1:0] a_q;
    logic [AW-1:0] p_q;
    logic [AW-1:0] prod;

    // Product of the current activation and the stored weight, widened to the sum width.
    always_comb begin
        prod = AW'(a_in) * AW'(w_q);
    end

    // Weight register: shifts in from above during load, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else if (load_en) begin
            w_q <= w_in;
        end
    end

    // Activation forward and partial-sum accumulate, one step per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            p_q <= '0;
        end else begin
            a_q <= a_in;
            p_q <= p_in + prod;
        end
    end

    assign w_out = w_q;
    assign a_out = a_q;
    assign p_out = p_q;

    // R2: outside the load phase the stored weight does not move.
    p_weight_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> (w_q == $past(w_q)));

    // R4: output partial sum is the previous input sum plus the previous product.
    p_mac_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (p_out == $past(p_in) + AW'($past(a_in)) * AW'($past(w_q))));

endmodule

// File: rtl/wsmm_vld_pipe.sv
// Valid tracker for the grid.
// A single shift line delays in_valid. Column j taps it after N+j stages,
// so its flag lines up with the result leaving the bottom of that column.
// Assumes: the caller skews activations one cycle per array row.
module wsmm_vld_pipe
    import wsmm_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic [N-1:0] out_valid
);

    localparam int DEPTH = valid_depth(N);

    logic [DEPTH-1:0] sr;

    // Shift line: stage 0 samples the input, each later stage copies the one before.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr[0] <= in_valid;
            for (int s = 1; s < DEPTH; s++) begin
                sr[s] <= sr[s-1];
            end
        end
    end

    for (genvar gj = 0; gj < N; gj++) begin : g_tap
        // Column tap: N-1+j is the stage index of an N+j-stage delay.
        assign out_valid[gj] = sr[N-1+gj];

        if (gj > 0) begin : g_step
            // R6: each column's valid lags its left neighbour by exactly one cycle.
            p_valid_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (out_valid[gj] == $past(out_valid[gj-1])));
        end
    end

endmodule

// File: rtl/wsmm_array.sv
// N x N weight-stationary systolic grid computing C = X * W.
// Weights shift down one row per load_en cycle. Activations enter each array row
// from the left (pre-skewed by the caller) and move right. Partial sums start at
// zero on the top edge and move down. Results leave the bottom edge with a
// per-column valid.
// Assumes: loading is finished before activations are streamed; unsigned data.
module wsmm_array
    import wsmm_pkg::*;
#(
    parameter int N  = 4,
    parameter int DW = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                load_en,
    input  logic [N*DW-1:0]                     load_row,
    input  logic                                in_valid,
    input  logic [N*DW-1:0]                     act_in,
    output logic [N-1:0]                        res_valid,
    output logic [N*wsmm_pkg::acc_width(DW,N)-1:0] res_out
);

    localparam int AW = acc_width(DW, N);

    // Weight chain: wch[i][j] feeds cell (i,j); wch[N] holds the bottom-row weights.
    logic [DW-1:0] wch [0:N][0:N-1];
    // Activation chain: act[i][j] feeds cell (i,j); act[i][N] leaves the right edge.
    logic [DW-1:0] act [0:N-1][0:N];
    // Partial-sum chain: ps[i][j] enters cell (i,j) from above; ps[N] is the result row.
    logic [AW-1:0] ps  [0:N][0:N-1];

    for (genvar gj = 0; gj < N; gj++) begin : g_col_edge
        // Top edge: weights from the load row, partial sums forced to zero.
        assign wch[0][gj] = load_row[gj*DW +: DW];
        assign ps[0][gj]  = '0;
        // Bottom edge: finished column sums.
        assign res_out[gj*AW +: AW] = ps[N][gj];
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_row_edge
        // Left edge: per-row activation from the input bus.
        assign act[gi][0] = act_in[gi*DW +: DW];
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            wsmm_cell #(
                .DW(DW),
                .AW(AW)
            ) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .load_en(load_en),
                .w_in   (wch[gi][gj]),
                .w_out  (wch[gi+1][gj]),
                .a_in   (act[gi][gj]),
                .a_out  (act[gi][gj+1]),
                .p_in   (ps[gi][gj]),
                .p_out  (ps[gi+1][gj])
            );

            // R2: during load every weight moves down exactly one row per edge.
            p_load_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
                load_en |=> (wch[gi+1][gj] == $past(wch[gi][gj])));

            // R3: activations advance exactly one column per edge, unchanged.
            p_act_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (act[gi][gj+1] == $past(act[gi][gj])));
        end
    end

    wsmm_vld_pipe #(
        .N(N)
    ) u_vld (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .out_valid(res_valid)
    );

    // R1: a reset edge leaves no valid result and zero data on the bottom edge.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> ((res_valid == '0) && (res_out == '0)));

endmodule

// File: tb/sim_wsmm_array.sv
`timescale 1ns/1ps
// Bench for wsmm_array on a 3x3 grid with 4-bit data.
// It streams skewed X rows and compares each column, at the cycle it is due,
// with C computed here from the requirements.
module sim_wsmm_array;

    localparam int N    = 3;
    localparam int DW   = 4;
    localparam int AW   = 2 * DW + $clog2(N);
    localparam int MMAX = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            load_en;
    logic [N*DW-1:0] load_row;
    logic            in_valid;
    logic [N*DW-1:0] act_in;
    logic [N-1:0]    res_valid;
    logic [N*AW-1:0] res_out;

    always #4 clk = ~clk;

    wsmm_array #(.N(N), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_row(load_row),
        .in_valid(in_valid), .act_in(act_in), .res_valid(res_valid), .res_out(res_out)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int unsigned seed = 32'h2468_ace1;
    int wm [N][N];
    int xm [MMAX][N];

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'hf);
    endfunction

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Shift W in, bottom row first, so row k of W lands in array row k (R2).
    task automatic load_weights();
        for (int r = 0; r < N; r++) begin
            @(negedge clk);
            load_en = 1'b1;
            for (int j = 0; j < N; j++) load_row[j*DW +: DW] = DW'(wm[N-1-r][j]);
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // Stream m skewed rows and check every column every cycle. load_row is
    // randomised throughout with load_en low, so any correct result also shows R2 hold.
    task automatic run_batch(input string tag, input int m, input bit [MMAX-1:0] mask);
        int seen = 0;
        int expn = 0;
        for (int c = 0; c <= m + 2 * N; c++) begin
            @(negedge clk);
            for (int j = 0; j < N; j++) begin
                int k;
                bit ev;
                int e;
                k  = c - N - j;
                ev = (k >= 0 && k < m) ? mask[k] : 1'b0;
                chk("R6", $sformatf("valid col %0d cyc %0d", j, c), int'(res_valid[j]), int'(ev));
                if (ev) begin
                    e = 0;
                    for (int i = 0; i < N; i++) e += xm[k][i] * wm[i][j];
                    chk(tag, $sformatf("data col %0d row %0d", j, k), int'(res_out[j*AW +: AW]), e);
                end
                if (res_valid[j]) seen++;
            end
            in_valid = (c < m) ? mask[c] : 1'b0;
            for (int j = 0; j < N; j++) load_row[j*DW +: DW] = DW'(rnd());
            for (int i = 0; i < N; i++) begin
                int k2;
                k2 = c - i;
                if (k2 >= 0 && k2 < m && mask[k2]) act_in[i*DW +: DW] = DW'(xm[k2][i]);
                else act_in[i*DW +: DW] = DW'(rnd());
            end
        end
        for (int k = 0; k < m; k++) if (mask[k]) expn++;
        chk("R7", "result count", seen, expn * N);
    endtask

    task automatic rand_x(input int m);
        for (int k = 0; k < m; k++) for (int i = 0; i < N; i++) xm[k][i] = rnd();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; load_en = 1'b0; in_valid = 1'b0; load_row = '0; act_in = '0;
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) wm[i][j] = 0;
        repeat (3) @(negedge clk);
        // R1: outputs clear during reset.
        chk("R1", "reset valid", int'(res_valid), 0);
        chk("R1", "reset data", int'(res_out), 0);
        rst_n = 1'b1;

        // R1: weights are zero after reset, so all results are zero.
        rand_x(4);
        run_batch("R1", 4, '1);

        // R2: distinct weights with unit-vector rows expose where each row landed.
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) wm[i][j] = i * N + j + 1;
        for (int k = 0; k < N; k++) for (int i = 0; i < N; i++) xm[k][i] = (i == k) ? 1 : 0;
        load_weights();
        run_batch("R2", N, '1);

        // R5: identity weights return X unchanged.
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) wm[i][j] = (i == j) ? 1 : 0;
        load_weights();
        rand_x(5);
        run_batch("R5", 5, '1);

        // R5, R3, R4, R7: sweep of random weights and batch sizes 1..MMAX.
        for (int s = 0; s < 40; s++) begin
            for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) wm[i][j] = rnd();
            load_weights();
            rand_x(1 + (s % MMAX));
            run_batch("R5", 1 + (s % MMAX), '1);
        end

        // R8: maximum operands give N*15*15 with no wrap.
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) wm[i][j] = 15;
        load_weights();
        for (int k = 0; k < 4; k++) for (int i = 0; i < N; i++) xm[k][i] = 15;
        run_batch("R8", 4, '1);

        // R6: gaps in input valid are kept; garbage sampled in the gaps is never flagged.
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) wm[i][j] = rnd();
        load_weights();
        rand_x(MMAX);
        run_batch("R6", MMAX, 8'b1011_0101);

        // R1: reset in mid-stream clears outputs at once and clears the weights.
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            in_valid = 1'b1;
            for (int i = 0; i < N; i++) act_in[i*DW +: DW] = DW'(rnd());
        end
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid reset valid", int'(res_valid), 0);
        chk("R1", "mid reset data", int'(res_out), 0);
        rst_n = 1'b1; in_valid = 1'b0; act_in = '0;
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) wm[i][j] = 0;
        rand_x(3);
        run_batch("R1", 3, '1);

        summary();
        $finish;
    end

endmodule